// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Programmable Divider

This block divides a fast input clock by a programmable integer ratio. It produces one output pulse per division period for a phase comparator. The ratio comes from a 15-bit word. The block does not count that ratio with one wide binary counter. It splits the word into a 12-bit main count M and a 3-bit swallow count A, and drives a prescaler that divides by either 8 or 9. Within each output period the prescaler runs A sub-cycles of nine clocks and then M − A sub-cycles of eight clocks. The total is N = 9A + 8(M − A) = 8M + A input clocks, so each step of the word moves the output frequency by one comparison period.

The word is sampled only at the boundary between output periods, so a period that has started always completes with the ratio it began with. Words that the pulse-swallow scheme cannot realise are replaced by the minimum ratio of 56 when they are sampled. These are words with M smaller than A, or words whose ratio is below 56. A second output toggles on every divided pulse, which gives a square wave at half the divided rate for test observation.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While rst_n is low on a clock edge, both outputs are low after that edge. The first output period after reset is 56 input clocks, whatever the ratio word holds: fpd_out is first high on the 56th rising edge after rst_n is sampled high.
- R2: ratio_word bits [14:3] form M and bits [2:0] form A. For a legal word, successive fpd_out pulses are 8·M + A input clocks apart, which is numerically equal to ratio_word.
- R3: fpd_out is high for exactly one input clock per output period.
- R4: A word with M < A, or with 8·M + A < 56, is treated as invalid and yields a period of 56 input clocks.
- R5: The extremes of the legal range are exact. Word 56 (M = 7, A = 0) gives 56 clocks and word 32767 (M = 4095, A = 7) gives 32767 clocks. Word 63 (M = A = 7, every sub-cycle divides by 9) gives 63 clocks.
- R6: ratio_word is sampled only on the clock edge that ends an output period. A change made during a period leaves that period's length unchanged and sets the length of the following one. Only the value present at the boundary counts.
- R7: fpd_half toggles on exactly the edges where fpd_out rises and is otherwise stable. It therefore has a period of 2N clocks and stays high for N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_word | input | 15 | Division word: M in [14:3], A in [2:0] |
| fpd_out | output | 1 | One-clock divided pulse, once every N clocks |
| fpd_half | output | 1 | Divided output toggled per pulse (divide-by-two test copy) |

## Verification
The pulse that ends a period is registered, so fpd_out and fpd_half change on the edge that ends the period, and the first pulse after reset is seen after the 56th edge. A new word sampled on a boundary edge shows up only in the gap between the next pair of pulses, one full period later. The bench therefore changes the word just after a pulse has been seen, expects the following gap to keep the old ratio, and expects the gap after that to carry the new one. All times are taken at falling edges from a free-running edge counter, so the gap between pulses is measured in whole input clocks, and the pulse width and the fpd_half level are read at the falling edge after each pulse.

// File: rtl/dmd_pkg.sv
// Package: shared defaults for the dual-modulus divider.
// Assumes the prescaler base is 2**(swallow width), as a pulse-swallow scheme requires.
package dmd_pkg;
    localparam int DEF_M_W       = 12;  // main counter width
    localparam int DEF_A_W       = 3;   // swallow counter width
    localparam int DEF_MIN_RATIO = 56;  // smallest ratio the scheme realises
endpackage

// File: rtl/dmd_prescaler.sv
// Dual-modulus prescaler: counts input clocks and divides by PRE_BASE or PRE_BASE+1.
// Assumes sel_plus1 changes only on the edge where sub_end is high.
module dmd_prescaler #(
    parameter int PRE_BASE = 8,
    localparam int CNT_W   = $clog2(PRE_BASE + 1)
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic sel_plus1,
    output logic sub_end
);
    logic [CNT_W-1:0] pc;

    // last clock of a sub-cycle depends on the chosen modulus
    assign sub_end = (pc == (sel_plus1 ? CNT_W'(PRE_BASE) : CNT_W'(PRE_BASE - 1)));

    // sub-cycle clock counter, wraps at the end of each sub-cycle
    always_ff @(posedge clk_in) begin
        if (!rst_n)       pc <= '0;
        else if (sub_end) pc <= '0;
        else              pc <= pc + CNT_W'(1);
    end

    // R2
    pc_range_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        pc <= CNT_W'(PRE_BASE));
endmodule

// File: rtl/dmd_word_clamp.sv
// Word decoder: splits the division word into main and swallow counts.
// Replaces words with M < A or a ratio below MIN_RATIO by MIN_RATIO.
module dmd_word_clamp #(
    parameter int M_W       = 12,
    parameter int A_W       = 3,
    parameter int MIN_RATIO = 56,
    localparam int N_W      = M_W + A_W,
    localparam int M_MIN    = MIN_RATIO >> A_W,
    localparam int A_MIN    = MIN_RATIO % (1 << A_W)
) (
    input  logic [N_W-1:0] word,
    output logic [M_W-1:0] m_cnt,
    output logic [A_W-1:0] a_cnt
);
    logic [M_W-1:0] raw_m;
    logic [A_W-1:0] raw_a;
    logic           bad;

    assign raw_m = word[N_W-1:A_W];
    assign raw_a = word[A_W-1:0];

    // the ratio 8M+A equals the word itself, so the range test is a plain compare
    always_comb begin
        bad = (raw_m < M_W'(raw_a)) || (word < N_W'(MIN_RATIO));
        if (bad) begin
            m_cnt = M_W'(M_MIN);
            a_cnt = A_W'(A_MIN);
        end else begin
            m_cnt = raw_m;
            a_cnt = raw_a;
        end
    end
endmodule

// File: rtl/dmd_swallow_ctrl.sv
// Swallow and main counters: choose the prescaler modulus for every sub-cycle and
// flag the last clock of an output period. Assumes loaded counts satisfy M >= A, M >= 1.
module dmd_swallow_ctrl #(
    parameter int M_W   = 12,
    parameter int A_W   = 3,
    parameter int M_RST = 7,
    parameter int A_RST = 0
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           sub_end,
    input  logic [M_W-1:0] nxt_m,
    input  logic [A_W-1:0] nxt_a,
    output logic           sel_plus1,
    output logic           cycle_end
);
    logic [M_W-1:0] m_rem;  // sub-cycles left in this period, current one included
    logic [A_W-1:0] a_rem;  // divide-by-(base+1) sub-cycles left

    assign sel_plus1 = (a_rem != '0);
    assign cycle_end = sub_end && (m_rem == M_W'(1));

    // reload at a period boundary, count down at each sub-cycle end
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            m_rem <= M_W'(M_RST);
            a_rem <= A_W'(A_RST);
        end else if (cycle_end) begin
            m_rem <= nxt_m;
            a_rem <= nxt_a;
        end else if (sub_end) begin
            m_rem <= m_rem - M_W'(1);
            if (a_rem != '0) a_rem <= a_rem - A_W'(1);
        end
    end

    // R4
    swallow_order_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (m_rem != '0) && (M_W'(a_rem) <= m_rem));
endmodule

// File: rtl/pulse_swallow_divider.sv
// Top: programmable divider N = 8M + A built from a dual-modulus prescaler and
// swallow/main counters. The word is sampled at period boundaries only.
// Outputs are registered; fpd_half toggles with every pulse.
module pulse_swallow_divider #(
    parameter int M_W       = dmd_pkg::DEF_M_W,
    parameter int A_W       = dmd_pkg::DEF_A_W,
    parameter int MIN_RATIO = dmd_pkg::DEF_MIN_RATIO,
    localparam int N_W      = M_W + A_W,
    localparam int PRE_BASE = 1 << A_W
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic [N_W-1:0] ratio_word,
    output logic           fpd_out,
    output logic           fpd_half
);
    logic [M_W-1:0] nxt_m;
    logic [A_W-1:0] nxt_a;
    logic           sel_plus1;
    logic           sub_end;
    logic           cycle_end;

    dmd_word_clamp #(.M_W(M_W), .A_W(A_W), .MIN_RATIO(MIN_RATIO)) u_clamp (
        .word (ratio_word),
        .m_cnt(nxt_m),
        .a_cnt(nxt_a)
    );

    dmd_prescaler #(.PRE_BASE(PRE_BASE)) u_pre (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .sel_plus1(sel_plus1),
        .sub_end  (sub_end)
    );

    dmd_swallow_ctrl #(
        .M_W(M_W), .A_W(A_W),
        .M_RST(MIN_RATIO >> A_W), .A_RST(MIN_RATIO % PRE_BASE)
    ) u_ctrl (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .sub_end  (sub_end),
        .nxt_m    (nxt_m),
        .nxt_a    (nxt_a),
        .sel_plus1(sel_plus1),
        .cycle_end(cycle_end)
    );

    // register the period-end pulse and its divide-by-two copy
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            fpd_out  <= 1'b0;
            fpd_half <= 1'b0;
        end else begin
            fpd_out <= cycle_end;
            if (cycle_end) fpd_half <= ~fpd_half;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk_in)
        !rst_n |=> (!fpd_out && !fpd_half));
    // R3
    fpd_width_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        fpd_out |=> !fpd_out);
    // R7
    half_toggle_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (fpd_half != $past(fpd_half)) |-> fpd_out);
endmodule

// File: tb/pulse_swallow_divider_test.sv
// Directed bench: measures pulse spacing in input clocks against 8M+A.
module pulse_swallow_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] word = 15'd100;
    logic        fpd, half;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int prev_exp = 56;

    pulse_swallow_divider uut (
        .clk_in(clk), .rst_n(rst_n), .ratio_word(word),
        .fpd_out(fpd), .fpd_half(half)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_ratio(input logic [14:0] w);
        int m = int'(w[14:3]);
        int a = int'(w[2:0]);
        int n = 8 * m + a;
        if (m < a || n < 56) return 56;
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int t);
        do @(negedge clk); while (!fpd);
        t = cyc;
    endtask

    // apply w right after a pulse; next gap keeps old ratio (R6), the one after uses w
    task automatic t_ratio(input logic [14:0] w, input string req);
        int t0, t1, t2;
        logic h1;
        wait_pulse(t0);
        word = w;
        wait_pulse(t1);
        h1 = half;
        check(t1 - t0 == prev_exp, "R6", t1 - t0, prev_exp);
        wait_pulse(t2);
        check(t2 - t1 == exp_ratio(w), req, t2 - t1, exp_ratio(w));
        check(half != h1, "R7", int'(half), int'(!h1));
        @(negedge clk);
        check(fpd == 1'b0, "R3", int'(fpd), 0);
        prev_exp = exp_ratio(w);
    endtask

    task automatic t_reset;
        int t;
        int base;
        rst_n = 1'b0;
        word = 15'd100;
        repeat (5) @(negedge clk);
        check(fpd == 1'b0 && half == 1'b0, "R1", int'({fpd, half}), 0);
        rst_n = 1'b1;
        base = cyc;
        wait_pulse(t);
        check(t - base == 56, "R1", t - base, 56);
        prev_exp = 100;
    endtask

    task automatic t_legal;
        t_ratio(15'd100, "R2");
        t_ratio({12'd20, 3'd3}, "R2");
        t_ratio({12'd9, 3'd1}, "R2");
    endtask

    task automatic t_random;
        for (int i = 0; i < 8; i++) begin
            logic [11:0] m = 12'($urandom_range(7, 300));
            logic [2:0]  a = 3'($urandom_range(0, 7));
            t_ratio({m, a}, "R2");
        end
    endtask

    task automatic t_invalid;
        t_ratio(15'd0, "R4");
        t_ratio({12'd3, 3'd5}, "R4");
        t_ratio({12'd6, 3'd6}, "R4");
        t_ratio({12'd6, 3'd7}, "R4");
        t_ratio(15'd55, "R4");
    endtask

    task automatic t_bounds;
        t_ratio(15'd56, "R5");
        t_ratio({12'd7, 3'd7}, "R5");
        t_ratio(15'h7FFF, "R5");
        t_ratio(15'd60, "R5");
    endtask

    // several changes inside one period: only the value at the boundary counts (R6)
    task automatic t_midcycle;
        int t0, t1, t2;
        wait_pulse(t0);
        word = 15'd200;
        repeat (20) @(negedge clk);
        word = 15'd77;
        wait_pulse(t1);
        check(t1 - t0 == prev_exp, "R6", t1 - t0, prev_exp);
        word = 15'd90;
        wait_pulse(t2);
        check(t2 - t1 == 77, "R6", t2 - t1, 77);
        prev_exp = 90;
    endtask

    // fpd_half high for exactly N clocks (R7)
    task automatic t_half_duty;
        int t0, hi;
        t_ratio(15'd70, "R2");
        wait_pulse(t0);
        hi = half ? 1 : 0;
        for (int k = 0; k < 2 * 70 - 1; k++) begin
            @(negedge clk);
            if (half) hi++;
        end
        check(hi == 70, "R7", hi, 70);
    endtask

    initial begin
        #(8 * 195000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_legal();
        t_random();
        t_invalid();
        t_bounds();
        t_midcycle();
        t_half_duty();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule